// File: doc/BRIEF.md
# Conditionally Loaded Program Counter

This block holds the address of the next instruction word for a small microcoded processor. In every clock cycle it does one of three things. It can take a new value from the shared data bus, step forward by one, or keep its current value. Microcode drives a step strobe and three condition-select bits. Each select bit names one sign class of the most recent ALU result: zero, strictly positive or strictly negative. The ALU status arrives already latched, as a zero flag and a negative flag. If any selected class matches that status, the counter takes the bus value.

Select bits combine by OR. Positive and negative together give a jump when the result is not zero, and all three together give an unconditional jump. A taken jump wins over a step requested in the same cycle. This gives a one-microinstruction skip: microcode places the counter's own value on the bus and asserts jump-if-nonzero together with the step strobe. A nonzero result reloads the current value, so the counter does not move. A zero result steps past one word. Issuing that microinstruction twice skips a two-word instruction. The counter value also goes to a bus-drive output that reads zero unless the output enable is high.

This block has no valid/ready handshake. It updates on every clock edge, and nothing downstream can stall it.

Top module: `pc_seq_counter`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets pc_q to 0x0000 on that edge.
- R2: When sel_zero is high and flag_zero is high, pc_q takes bus_in at the next edge.
- R3: When sel_pos is high and both flag_zero and flag_neg are low, pc_q takes bus_in at the next edge.
- R4: When sel_neg is high and flag_neg is high, pc_q takes bus_in at the next edge.
- R5: When no selected condition matches and step_en is high, pc_q increases by one at the next edge.
- R6: When a selected condition matches and step_en is also high, pc_q takes bus_in and does not step.
- R7: A step from 0xFFFF gives 0x0000.
- R8: When no selected condition matches and step_en is low, pc_q keeps its value. This also holds when select bits are set but their conditions are false.
- R9: pc_bus equals pc_q while pc_oe is high and is 0x0000 while pc_oe is low.
- R10: With bus_in equal to pc_q, and sel_pos, sel_neg and step_en all high, pc_q does not change after a nonzero result and moves up by one after a zero result. Two such cycles after a zero result move it up by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | 16 | Value on the shared bus, used as the load value |
| step_en | input | 1 | Request to step the counter by one |
| sel_zero | input | 1 | Load if the latched result is zero |
| sel_pos | input | 1 | Load if the latched result is greater than zero |
| sel_neg | input | 1 | Load if the latched result is less than zero |
| flag_zero | input | 1 | Latched ALU status: the result was zero |
| flag_neg | input | 1 | Latched ALU status: the result was negative |
| pc_oe | input | 1 | Enable for placing the counter on the bus |
| pc_q | output | 16 | Current counter value |
| pc_bus | output | 16 | Counter value gated by pc_oe |

## Verification
The bench builds the block with its defaults: a width of 16 and a reset value of zero. At that width the wrap case is reached directly by loading 0xFFFF and stepping once. The load, step and hold behaviour is driven with every combination of select bits against each of the three status classes. The skip idiom is driven with the bench feeding the counter's own value back onto bus_in, as the chip's bus multiplexer would.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef struct packed {
    logic zero;
    logic pos;
    logic neg;
  } cond_sel_t;

  typedef enum logic [1:0] {
    NXT_HOLD = 2'd0,
    NXT_STEP = 2'd1,
    NXT_LOAD = 2'd2
  } next_op_t;
endpackage

// File: rtl/pc_cond_eval.sv
module pc_cond_eval
  import pc_seq_pkg::*;
(
  input  cond_sel_t sel,
  input  logic      flag_zero,
  input  logic      flag_neg,
  output logic      taken
);
  localparam int NUM_CLASS = 3;

  logic [NUM_CLASS-1:0] class_hit;
  logic [NUM_CLASS-1:0] sel_vec;

  assign class_hit = {flag_zero, (~flag_zero & ~flag_neg), flag_neg};
  assign sel_vec   = {sel.zero, sel.pos, sel.neg};

  logic [NUM_CLASS-1:0] match;
  for (genvar g = 0; g < NUM_CLASS; g++) begin : g_match
    assign match[g] = sel_vec[g] & class_hit[g];
  end

  assign taken = |match;
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pc_seq_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             taken,
  input  logic             step_en,
  input  logic [WIDTH-1:0] pc_cur,
  input  logic [WIDTH-1:0] load_val,
  output next_op_t         op,
  output logic [WIDTH-1:0] pc_nxt
);
  localparam logic [WIDTH-1:0] STEP_ONE = WIDTH'(1);

  always_comb begin
    if (taken)        op = NXT_LOAD;
    else if (step_en) op = NXT_STEP;
    else              op = NXT_HOLD;
  end

  always_comb begin
    unique case (op)
      NXT_LOAD: pc_nxt = load_val;
      NXT_STEP: pc_nxt = pc_cur + STEP_ONE;
      default:  pc_nxt = pc_cur;
    endcase
  end
endmodule

// File: rtl/pc_state_reg.sv
module pc_state_reg #(
  parameter int               WIDTH     = 16,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/pc_seq_counter.sv
module pc_seq_counter
  import pc_seq_pkg::*;
#(
  parameter int               WIDTH     = 16,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] bus_in,
  input  logic             step_en,
  input  logic             sel_zero,
  input  logic             sel_pos,
  input  logic             sel_neg,
  input  logic             flag_zero,
  input  logic             flag_neg,
  input  logic             pc_oe,
  output logic [WIDTH-1:0] pc_q,
  output logic [WIDTH-1:0] pc_bus
);
  cond_sel_t        sel;
  logic             taken;
  next_op_t         op;
  logic [WIDTH-1:0] pc_nxt;

  assign sel = '{zero: sel_zero, pos: sel_pos, neg: sel_neg};

  pc_cond_eval u_cond (
    .sel       (sel),
    .flag_zero (flag_zero),
    .flag_neg  (flag_neg),
    .taken     (taken)
  );

  pc_next_sel #(.WIDTH(WIDTH)) u_next (
    .taken    (taken),
    .step_en  (step_en),
    .pc_cur   (pc_q),
    .load_val (bus_in),
    .op       (op),
    .pc_nxt   (pc_nxt)
  );

  pc_state_reg #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (pc_nxt),
    .q   (pc_q)
  );

  assign pc_bus = pc_oe ? pc_q : '0;
endmodule

// File: rtl/pc_seq_counter_chk.sv
module pc_seq_counter_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] bus_in,
  input logic             step_en,
  input logic             sel_zero,
  input logic             sel_pos,
  input logic             sel_neg,
  input logic             flag_zero,
  input logic             flag_neg,
  input logic             pc_oe,
  input logic [WIDTH-1:0] pc_q,
  input logic [WIDTH-1:0] pc_bus
);
  logic hit_z, hit_p, hit_n, any_hit;
  assign hit_z   = sel_zero & flag_zero;
  assign hit_p   = sel_pos & ~flag_zero & ~flag_neg;
  assign hit_n   = sel_neg & flag_neg;
  assign any_hit = hit_z | hit_p | hit_n;

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> pc_q == '0);

  p_load_zero_r2: assert property (@(posedge clk) disable iff (rst)
    hit_z |=> pc_q == $past(bus_in));

  p_load_pos_r3: assert property (@(posedge clk) disable iff (rst)
    hit_p |=> pc_q == $past(bus_in));

  p_load_neg_r4: assert property (@(posedge clk) disable iff (rst)
    hit_n |=> pc_q == $past(bus_in));

  // R5 and R7: the step is modulo the width
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!any_hit && step_en) |=> pc_q == WIDTH'($past(pc_q) + 1'b1));

  p_jump_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (any_hit && step_en && bus_in != WIDTH'(pc_q + 1'b1))
      |=> pc_q != WIDTH'($past(pc_q) + 1'b1));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!any_hit && !step_en) |=> $stable(pc_q));

  p_bus_on_r9: assert property (@(posedge clk) disable iff (rst)
    pc_oe |-> pc_bus == pc_q);

  p_bus_off_r9: assert property (@(posedge clk) disable iff (rst)
    !pc_oe |-> pc_bus == '0);
endmodule

bind pc_seq_counter pc_seq_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_pc_seq_counter.sv
module test_pc_seq_counter;
  localparam int  W      = 16;
  localparam time CLK_PER = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] bus_in;
  logic         step_en, sel_zero, sel_pos, sel_neg, flag_zero, flag_neg, pc_oe;
  logic [W-1:0] pc_q, pc_bus;

  always #(CLK_PER/2) clk = ~clk;

  pc_seq_counter #(.WIDTH(W)) i_pc_seq_counter (
    .clk(clk), .rst(rst), .bus_in(bus_in), .step_en(step_en),
    .sel_zero(sel_zero), .sel_pos(sel_pos), .sel_neg(sel_neg),
    .flag_zero(flag_zero), .flag_neg(flag_neg), .pc_oe(pc_oe),
    .pc_q(pc_q), .pc_bus(pc_bus)
  );

  typedef struct {
    logic [W-1:0] pc;
    logic [W-1:0] bus;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  int           n_cmp  = 0;
  int           n_bad  = 0;
  logic [W-1:0] model  = '0;
  bit           done   = 0;

  // Driver: apply one cycle of stimulus at the falling edge, queue the result
  task automatic drive(input logic [W-1:0] b, input logic st,
                       input logic jz, input logic jp, input logic jn,
                       input logic fz, input logic fn, input logic oe,
                       input string tag);
    logic hit;
    exp_t e;
    @(negedge clk);
    rst = 1'b0; bus_in = b; step_en = st; sel_zero = jz; sel_pos = jp;
    sel_neg = jn; flag_zero = fz; flag_neg = fn; pc_oe = oe;
    hit = (jz & fz) | (jp & ~fz & ~fn) | (jn & fn);
    if (hit)     model = b;
    else if (st) model = model + 16'd1;
    e.pc = model; e.bus = oe ? model : '0; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic do_reset(input string tag);
    exp_t e;
    @(negedge clk);
    rst = 1'b1; step_en = 1'b1; bus_in = 16'hABCD;
    sel_zero = 1'b1; sel_pos = 1'b1; sel_neg = 1'b1; pc_oe = 1'b1;
    model = '0;
    e.pc = '0; e.bus = '0; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PER/4);
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (pc_q !== e.pc) begin
        n_bad++;
        $display("FAIL %s: pc_q actual %h expected %h", e.tag, pc_q, e.pc);
      end
      if (e.tag != "R1" && e.tag != "R1b") begin
        n_cmp++;
        if (pc_bus !== e.bus) begin
          n_bad++;
          $display("FAIL R9 (%s): pc_bus actual %h expected %h", e.tag, pc_bus, e.bus);
        end
      end
    end
  end

  initial begin
    #(CLK_PER * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_in = '0; step_en = 0; sel_zero = 0; sel_pos = 0; sel_neg = 0;
    flag_zero = 0; flag_neg = 0; pc_oe = 0;
    do_reset("R1");
    // R5: plain steps
    drive(16'h0000, 1, 0, 0, 0, 0, 0, 1, "R5");
    drive(16'h0000, 1, 0, 0, 0, 0, 0, 0, "R5");
    // R8: hold, including selected-but-false conditions
    drive(16'h5555, 0, 0, 0, 0, 1, 0, 1, "R8");
    drive(16'h5555, 0, 1, 0, 0, 0, 1, 1, "R8");
    drive(16'h5555, 0, 0, 1, 0, 1, 0, 0, "R8");
    drive(16'h5555, 0, 0, 0, 1, 0, 0, 1, "R8");
    drive(16'h5555, 1, 0, 1, 0, 0, 1, 1, "R5");
    // R2/R3/R4 loads
    drive(16'h1234, 0, 1, 0, 0, 1, 0, 1, "R2");
    drive(16'h2345, 0, 0, 1, 0, 0, 0, 1, "R3");
    drive(16'h3456, 0, 0, 0, 1, 0, 1, 0, "R4");
    drive(16'h4567, 0, 1, 1, 1, 0, 0, 1, "R3");
    // R6: jump beats step
    drive(16'h8000, 1, 1, 1, 1, 0, 1, 1, "R6");
    drive(16'h9000, 1, 1, 0, 0, 1, 0, 1, "R6");
    // sweep all select patterns over all status classes
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 3; c++) begin
        drive(16'h0100 + 16'(s * 4 + c), (s[0] ^ c[0]), s[2], s[1], s[0],
              (c == 0), (c == 2), s[1], "R8");
      end
    end
    // R7: wrap
    drive(16'hFFFF, 0, 1, 1, 1, 0, 0, 1, "R2");
    drive(16'h0000, 1, 0, 0, 0, 0, 0, 1, "R7");
    // R10: skip idiom, bus fed with the counter value
    drive(16'h0010, 0, 1, 1, 1, 1, 0, 1, "R2");
    drive(model, 1, 0, 1, 1, 0, 1, 1, "R10");
    drive(model, 1, 0, 1, 1, 0, 0, 1, "R10");
    drive(model, 1, 0, 1, 1, 1, 0, 1, "R10");
    drive(model, 1, 0, 1, 1, 1, 0, 1, "R10");
    // R1: reset mid-run
    do_reset("R1b");
    drive(16'h7777, 0, 0, 0, 0, 0, 0, 1, "R8");
    @(negedge clk);
    rst = 1'b0; step_en = 0; sel_zero = 0; sel_pos = 0; sel_neg = 0;
    repeat (3) @(posedge clk);
    #(CLK_PER/2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule